// File: doc/BRIEF.md
# ATM Receive Cell Packer

This block sits between a byte-wide cell receive port and the cell FIFO that feeds reassembly. Every incoming octet carries an odd-parity bit, and a start-of-cell strobe marks the first octet of each 53-octet cell. The block follows cell framing from that strobe. It drops the header check octet, packs the other 52 octets big-endian into thirteen 32-bit words, and hands whole cells downstream one word per handshake.

A cell is assembled in a local thirteen-word staging buffer. It becomes visible downstream only once its last octet has arrived intact. Cells that are cut short by an early start-of-cell, and cells that contain any parity fault, never leave the block. A sticky flag records that a parity fault was seen.

Both data edges are valid/ready. On the byte side, `rx_ready` is the receive enable: a byte is taken on a rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` falls while a finished cell waits in the staging buffer, so the sender must hold its byte until `rx_ready` returns. On the word side, a word moves on a rising edge where `cw_valid` and `cw_ready` are both high. While `cw_ready` is low, the block keeps the same word and the same last marker on its outputs.

Top module: `atm_rx_cell_packer`

## Requirements
- R1: After reset, `cw_valid` is 0, `rx_ready` is 1 and `rx_par_err` is 0.
- R2: A byte counts only when `rx_valid` and `rx_ready` are both high at a rising edge. A byte taken with `rx_sop` low while no cell is open is ignored and produces no output word.
- R3: Octet index 4 (counting from 0, where index 0 is the byte with `rx_sop` high) is dropped. Each remaining octet gets a payload index p (its octet index, minus one for indices above 4). It goes to word p/4, in bits [31-8*(p%4) -: 8], so octet 0 lands in bits 31:24 of the first word.
- R4: A cell is released only after its 53rd octet has been taken. `cw_valid` rises in the cycle after that octet, and `cw_last` is high only on the 13th word.
- R5: If a byte with `rx_sop` high is taken while a cell is open, the open partial cell is discarded and that byte becomes octet 0 of a new cell.
- R6: A taken octet is good when the XOR of `rx_par` and `rx_data` is 1. A bad octet inside a cell sets `rx_par_err`, which stays 1 until reset. The whole cell containing a bad octet is discarded.
- R7: `rx_ready` is 0 from the cycle after a cell is committed until the cycle after its 13th word is handed off.
- R8: While `cw_valid` is 1 and `cw_ready` is 0, `cw_data` and `cw_last` stay unchanged. Each handshake advances to the next word, in payload order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte present on the receive side |
| rx_data | input | 8 | Received octet |
| rx_par | input | 1 | Odd-parity bit for `rx_data` |
| rx_sop | input | 1 | Octet is the first of a cell |
| rx_ready | output | 1 | Receive enable; low while a finished cell is held |
| cw_valid | output | 1 | Cell word available downstream |
| cw_data | output | 32 | Packed cell word, earliest octet in bits 31:24 |
| cw_last | output | 1 | Marks the 13th word of a cell |
| cw_ready | input | 1 | Downstream FIFO can take a word |
| rx_par_err | output | 1 | Sticky parity-fault flag |

## Verification
The assertions check four things on every cycle. A held word stays stable under back-pressure. The last marker falls on exactly the thirteenth handed-off word. Every release follows a taken octet that completes a 53-octet count from a start-of-cell. The parity flag, once set, never clears. Only the bench's scenarios can show that the right octet is dropped, that bytes land in the right lanes, and that truncated, stray and faulty cells never reach the output. Those properties need a reference model of cell contents, which the bench builds from its own stimulus.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
  localparam int unsigned CELL_OCTETS_DEF = 53;
  localparam int unsigned HEC_POS_DEF     = 4;
  localparam int unsigned LANES_DEF       = 4;

  typedef logic [7:0] octet_t;

  // Odd parity: data plus parity bit must carry an odd number of ones.
  function automatic logic odd_par_ok(octet_t d, logic p);
    return ^{p, d};
  endfunction
endpackage

// File: rtl/cell_octet_seq.sv
module cell_octet_seq
  import atm_rx_pkg::*;
#(
  parameter int unsigned CELL_OCTETS = CELL_OCTETS_DEF,
  parameter int unsigned HEC_POS     = HEC_POS_DEF,
  parameter int unsigned LANES       = LANES_DEF,
  parameter int unsigned IDX_W       = $clog2(CELL_OCTETS),
  parameter int unsigned WIDX_W      = 4,
  parameter int unsigned LANE_W      = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sop,
  input  octet_t            data,
  input  logic              par,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_word,
  output logic [LANE_W-1:0] wr_lane,
  output octet_t            wr_byte,
  output logic              commit,
  output logic              par_err
);
  logic [IDX_W-1:0] idx_q;
  logic             open_q;
  logic             bad_q;
  logic             start, cont, last, ok, is_hec;
  logic [IDX_W-1:0] pos, pidx;

  always_comb begin
    start   = take && sop;
    cont    = take && !sop && open_q;
    ok      = odd_par_ok(data, par);
    pos     = start ? '0 : idx_q;
    is_hec  = (pos == IDX_W'(HEC_POS));
    pidx    = (pos > IDX_W'(HEC_POS)) ? pos - 1'b1 : pos;
    wr_en   = (start || cont) && !is_hec;
    wr_word = WIDX_W'(pidx / LANES);
    wr_lane = LANE_W'(LANES - 1) - LANE_W'(pidx % LANES);
    wr_byte = data;
    last    = cont && (idx_q == IDX_W'(CELL_OCTETS - 1));
    commit  = last && !bad_q && ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      open_q  <= 1'b0;
      bad_q   <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (start) begin
        open_q <= 1'b1;
        idx_q  <= IDX_W'(1);
        bad_q  <= !ok;
      end else if (cont) begin
        bad_q <= bad_q || !ok;
        if (last) begin
          open_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if ((start || cont) && !ok) par_err <= 1'b1;
    end
  end
endmodule

// File: rtl/cell_stage_buf.sv
module cell_stage_buf #(
  parameter int unsigned WORDS  = 13,
  parameter int unsigned LANES  = 4,
  parameter int unsigned WIDX_W = $clog2(WORDS),
  parameter int unsigned LANE_W = $clog2(LANES),
  parameter int unsigned DW     = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [7:0]        wr_byte,
  input  logic              commit,
  output logic              full,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  input  logic              out_ready
);
  logic [DW-1:0]     words [WORDS];
  logic [WIDX_W-1:0] rd_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_word == WIDX_W'(w)) word_q[wr_lane*8 +: 8] <= wr_byte;
    end
    assign words[w] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      rd_q <= '0;
    end else if (commit) begin
      full <= 1'b1;
      rd_q <= '0;
    end else if (full && out_ready) begin
      if (rd_q == WIDX_W'(WORDS - 1)) begin
        full <= 1'b0;
        rd_q <= '0;
      end else begin
        rd_q <= rd_q + 1'b1;
      end
    end
  end

  assign out_valid = full;
  assign out_data  = words[rd_q];
  assign out_last  = full && (rd_q == WIDX_W'(WORDS - 1));
endmodule

// File: rtl/atm_rx_cell_packer.sv
module atm_rx_cell_packer
  import atm_rx_pkg::*;
#(
  parameter int unsigned CELL_OCTETS = CELL_OCTETS_DEF,
  parameter int unsigned HEC_POS     = HEC_POS_DEF,
  parameter int unsigned LANES       = LANES_DEF,
  localparam int unsigned WORDS      = (CELL_OCTETS - 1) / LANES,
  localparam int unsigned WIDX_W     = $clog2(WORDS),
  localparam int unsigned LANE_W     = $clog2(LANES),
  localparam int unsigned IDX_W      = $clog2(CELL_OCTETS),
  localparam int unsigned DW         = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_par,
  input  logic          rx_sop,
  output logic          rx_ready,
  output logic          cw_valid,
  output logic [DW-1:0] cw_data,
  output logic          cw_last,
  input  logic          cw_ready,
  output logic          rx_par_err
);
  logic              take, full, wr_en, commit;
  logic [WIDX_W-1:0] wr_word;
  logic [LANE_W-1:0] wr_lane;
  octet_t            wr_byte;

  assign rx_ready = !full;
  assign take     = rx_valid && rx_ready;

  cell_octet_seq #(
    .CELL_OCTETS(CELL_OCTETS), .HEC_POS(HEC_POS), .LANES(LANES),
    .IDX_W(IDX_W), .WIDX_W(WIDX_W), .LANE_W(LANE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(rx_sop), .data(rx_data),
    .par(rx_par), .wr_en(wr_en), .wr_word(wr_word), .wr_lane(wr_lane),
    .wr_byte(wr_byte), .commit(commit), .par_err(rx_par_err)
  );

  cell_stage_buf #(
    .WORDS(WORDS), .LANES(LANES), .WIDX_W(WIDX_W), .LANE_W(LANE_W), .DW(DW)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_lane(wr_lane), .wr_byte(wr_byte), .commit(commit), .full(full),
    .out_valid(cw_valid), .out_data(cw_data), .out_last(cw_last),
    .out_ready(cw_ready)
  );
endmodule

// File: rtl/atm_rx_cell_packer_chk.sv
module atm_rx_cell_packer_chk #(
  parameter int unsigned CELL_OCTETS = 53,
  parameter int unsigned WORDS       = 13,
  parameter int unsigned DW          = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [7:0]    rx_data,
  input logic          rx_par,
  input logic          rx_sop,
  input logic          rx_ready,
  input logic          cw_valid,
  input logic [DW-1:0] cw_data,
  input logic          cw_last,
  input logic          cw_ready,
  input logic          rx_par_err
);
  localparam int unsigned CW = $clog2(CELL_OCTETS + 1);
  localparam int unsigned BW = $clog2(WORDS + 1);

  logic [CW-1:0] oct_cnt;
  logic [BW-1:0] beat_cnt;
  logic          acc;

  assign acc = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_cnt  <= '0;
      beat_cnt <= '0;
    end else begin
      if (acc) begin
        if (rx_sop) oct_cnt <= CW'(1);
        else if (oct_cnt != 0 && oct_cnt < CW'(CELL_OCTETS)) oct_cnt <= oct_cnt + 1'b1;
        else oct_cnt <= '0;
      end
      if (cw_valid && cw_ready) beat_cnt <= cw_last ? '0 : beat_cnt + 1'b1;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_data) && $stable(cw_last));

  // R4
  last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && cw_last |-> beat_cnt == BW'(WORDS - 1));

  // R4
  full_cell_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_valid) |-> oct_cnt == CW'(CELL_OCTETS));

  // R4
  release_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_valid) |-> $past(acc));

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_err |=> rx_par_err);

  // R6
  sop_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && rx_sop && !(^{rx_par, rx_data}) |=> rx_par_err);
endmodule

bind atm_rx_cell_packer atm_rx_cell_packer_chk #(
  .CELL_OCTETS(CELL_OCTETS), .WORDS(WORDS), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_par(rx_par), .rx_sop(rx_sop), .rx_ready(rx_ready),
  .cw_valid(cw_valid), .cw_data(cw_data), .cw_last(cw_last),
  .cw_ready(cw_ready), .rx_par_err(rx_par_err)
);

// File: tb/atm_rx_cell_packer_tb.sv
module atm_rx_cell_packer_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_valid = 0, rx_par = 0, rx_sop = 0, cw_ready = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready, cw_valid, cw_last, rx_par_err;
  logic [31:0] cw_data;

  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  bit          stall = 0;
  bit          done = 0;
  int          beat = 0;
  logic [7:0]  cb [53];

  always #10 clk = ~clk;

  atm_rx_cell_packer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par(rx_par), .rx_sop(rx_sop), .rx_ready(rx_ready),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_last(cw_last),
    .cw_ready(cw_ready), .rx_par_err(rx_par_err)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // R3 reference packing: drop octet 4, big-endian lanes
  task automatic push_expected();
    logic [31:0] w [13];
    for (int k = 0; k < 53; k++) begin
      if (k != 4) begin
        int p;
        p = (k > 4) ? k - 1 : k;
        w[p/4][31 - 8*(p%4) -: 8] = cb[k];
      end
    end
    for (int i = 0; i < 13; i++) exp_q.push_back(w[i]);
  endtask

  task automatic send_byte(logic [7:0] d, bit sop, bit bad);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_sop = sop;
    rx_par = bad ? ^d : ~^d;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      rx_valid = 0; rx_sop = 0;
    end
  endtask

  task automatic send_cell(int len, int bad_at, bit gaps);
    for (int k = 0; k < len; k++) begin
      send_byte(cb[k], k == 0, k == bad_at);
      if (gaps && ($urandom % 5 == 0)) idle(1);
    end
    if (len == 53 && bad_at < 0) push_expected();
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    idle(3);
  endtask

  // Output monitor and back-pressure driver
  initial begin
    forever begin
      @(negedge clk);
      cw_ready = stall ? 1'b0 : ($urandom % 4 != 0);
      #1;
      if (rst_n && cw_valid && cw_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2/R5/R6 unexpected word", cw_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(cw_data == e, "R3 word data", cw_data, e);
          check(cw_last == (beat == 12), "R4 last marker", 32'(cw_last), 32'(beat == 12));
        end
        beat = cw_last ? 0 : beat + 1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cw_valid == 0, "R1 cw_valid", 32'(cw_valid), 0);
    check(rx_ready == 1, "R1 rx_ready", 32'(rx_ready), 1);
    check(rx_par_err == 0, "R1 rx_par_err", 32'(rx_par_err), 0);
    rst_n = 1;

    // R2 stray bytes without start-of-cell, then a known cell under stall
    stall = 1;
    for (int i = 0; i < 5; i++) send_byte(8'hE0 + 8'(i), 0, 0);
    for (int k = 0; k < 53; k++) cb[k] = 8'(k + 1);
    send_cell(53, -1, 0);
    idle(3);
    check(cw_valid == 1, "R4 cell released", 32'(cw_valid), 1);
    check(rx_ready == 0, "R7 rx_ready low while held", 32'(rx_ready), 0);
    check(cw_data == 32'h01020304, "R3 first word", cw_data, 32'h01020304);
    held = cw_data;
    idle(4);
    check(cw_data == held && cw_valid, "R8 held under stall", cw_data, held);
    stall = 0;
    #1;
    // R3 second word skips octet index 4 (value 05)
    @(negedge clk);
    drain();
    check(rx_ready == 1, "R7 rx_ready back after drain", 32'(rx_ready), 1);
    check(exp_q.size() == 0, "R2 no extra words from stray bytes", exp_q.size(), 0);

    // R5 truncated cell then full cell
    for (int k = 0; k < 53; k++) cb[k] = 8'($urandom);
    send_cell(20, -1, 0);
    for (int k = 0; k < 53; k++) cb[k] = 8'($urandom);
    send_cell(53, -1, 1);
    idle(1);
    drain();
    check(exp_q.size() == 0, "R5 only full cell delivered", exp_q.size(), 0);

    // R6 parity fault mid-cell
    check(rx_par_err == 0, "R6 flag clear before fault", 32'(rx_par_err), 0);
    for (int k = 0; k < 53; k++) cb[k] = 8'($urandom);
    send_cell(53, 30, 0);
    idle(3);
    check(rx_par_err == 1, "R6 flag set", 32'(rx_par_err), 1);
    check(cw_valid == 0, "R6 faulty cell discarded", 32'(cw_valid), 0);
    for (int k = 0; k < 53; k++) cb[k] = 8'($urandom);
    send_cell(53, -1, 0);
    idle(1);
    drain();
    check(rx_par_err == 1, "R6 flag sticky", 32'(rx_par_err), 1);

    // Random mix: truncations (R5), faults (R6), stray bytes (R2), gaps
    for (int c = 0; c < 60; c++) begin
      int r;
      r = $urandom % 10;
      for (int k = 0; k < 53; k++) cb[k] = 8'($urandom);
      if (r == 0) begin
        send_cell(1 + $urandom % 52, -1, 1);
      end else begin
        send_cell(53, (r == 1) ? int'($urandom % 53) : -1, 1);
        if ($urandom % 3 == 0) begin
          for (int g = 0; g < 3; g++) send_byte(8'($urandom), 0, 0);
        end
        idle($urandom % 3);
      end
    end
    for (int k = 0; k < 53; k++) cb[k] = 8'($urandom);
    send_cell(53, -1, 1);
    idle(1);
    drain();
    check(exp_q.size() == 0, "R4 all expected cells delivered", exp_q.size(), 0);
    check(cw_valid == 0, "R7 idle after drain", 32'(cw_valid), 0);
    done = 1;
    summary();
  end
endmodule